// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of an 8-bit microcontroller's multiplexed external memory bus: an active-high address-latch strobe and an active-low program-read strobe. It runs from the oscillator clock. A machine cycle is twelve oscillator periods, grouped as six states of two phases each. The block publishes the current phase index so that neighbouring bus logic can align with it.

At the start of each machine cycle the block captures four attributes. They say whether the cycle moves data to or from external data memory, whether it reads a code constant, whether the latch-quiet control bit is set, and whether the core is fetching from external program memory. The strobes are not plain clock dividers. A data-memory cycle drops its first latch pulse and both program-read pulses. The quiet bit parks the latch strobe high except in data-move or code-constant cycles, and external fetch mode cancels the quiet bit. The block also filters the asynchronous reset pin into an internal reset. That reset only fires once the pin has stayed high for two whole machine cycles.

Top module: `bus_strobe_gen`

## Requirements
- R1: With quiet=0 and no data access, `addr_latch` is high in phases 0-1 and 6-7 and low in every other phase. That gives two-period pulses at one sixth of the clock rate.
- R2: In a cycle captured with `mc_xdata`=1 and the latch strobe enabled, the phase 0-1 pulse is omitted and the phase 6-7 pulse remains.
- R3: With quiet=1 and ext=0, `addr_latch` stays high for all 12 phases unless the cycle has `mc_xdata`=1 or `mc_code_rd`=1. In those cycles it shows the R1/R2 waveform.
- R4: With ext=1, the quiet bit has no effect: `addr_latch` follows R1/R2.
- R5: With ext=1 and no data access, `prog_rd_n` is low in phases 3-5 and 9-11 and high elsewhere. With ext=0, it stays high for the whole cycle.
- R6: In a cycle with `mc_xdata`=1, `prog_rd_n` stays high for all 12 phases.
- R7: The access inputs are captured only on the clock edge that enters phase 0. Changes during a cycle do not alter that cycle's strobes.
- R8: `rst_int` rises on the 26th rising edge after `rst_pin` goes high: two synchronizer edges plus 24 qualifying edges. A pin pulse shorter than that leaves `rst_int` low and the phase count undisturbed. `rst_int` falls on the third edge after the pin drops.
- R9: While `rst_int` is high, `addr_latch` is 0, `prog_rd_n` is 1 and `mc_phase` is 0 from the following edge on. On the second edge after `rst_int` falls, phase 0 of a full machine cycle begins.
- R10: `mc_phase` counts 0 through 11 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Asynchronous reset pin, active high |
| mc_xdata | input | 1 | Cycle accesses external data memory |
| mc_code_rd | input | 1 | Cycle reads a code constant |
| latch_quiet | input | 1 | Latch-quiet control bit |
| ext_fetch | input | 1 | Core executes from external program memory |
| addr_latch | output | 1 | Address-latch strobe, active high |
| prog_rd_n | output | 1 | Program-read strobe, active low |
| mc_phase | output | 4 | Phase index within the machine cycle |
| rst_int | output | 1 | Qualified internal reset |

## Verification
The bench steps the phase-exact waveform through every mix of the four attributes. Dropping the wrong latch pulse in a data cycle would move a high level into phases 0-1 or out of 6-7. Leaving program reads alive in such a cycle would show a low `prog_rd_n` in phase 3. Letting the quiet bit act during external fetch would park the latch strobe high. A design that samples the attributes mid-cycle is caught by toggling them at phase 4 and requiring the cycle to finish unchanged. The reset filter is checked for its exact rise and fall edges, and a short pin pulse must neither reset the block nor shift the phase count.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    // Attributes of one machine cycle, captured when phase 0 is entered.
    typedef struct packed {
        logic xdata;    // external data-memory access
        logic code_rd;  // code-constant read
        logic quiet;    // latch strobe parked unless data move
        logic ext;      // fetching from external program memory
    } mc_attr_t;

endpackage

// File: rtl/bsg_rst_qual.sv
module bsg_rst_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic rst_int
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   rst;
    } st_t;

    st_t st_d, st_q;

    // A low pin clears the count and the reset, so the chain settles
    // on its own once the pin has been seen low.
    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], rst_pin};
        if (!st_q.sync[SYNC_STAGES-1]) begin
            st_d.cnt = '0;
            st_d.rst = 1'b0;
        end else begin
            if (st_q.cnt != CNT_W'(HOLD_CYCLES)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_d.cnt == CNT_W'(HOLD_CYCLES)) begin
                st_d.rst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_int = st_q.rst;

endmodule

// File: rtl/bsg_cycle_seq.sv
module bsg_cycle_seq
    import bus_strobe_pkg::*;
#(
    parameter int MC_LEN  = 12,
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  mc_attr_t           attr_in,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] phase_nx,
    output mc_attr_t           attr_nx
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               primed;
        mc_attr_t           attr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.phase  = '0;
            st_d.primed = 1'b0;
            st_d.attr   = '0;
        end else if (!st_q.primed) begin
            // first edge after reset: replay phase 0 as a real cycle start
            st_d.phase  = '0;
            st_d.primed = 1'b1;
            st_d.attr   = attr_in;
        end else if (st_q.phase == PHASE_W'(MC_LEN - 1)) begin
            st_d.phase = '0;
            st_d.attr  = attr_in;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase    = st_q.phase;
    assign phase_nx = st_d.phase;
    assign attr_nx  = st_d.attr;

endmodule

// File: rtl/bsg_strobe_shape.sv
module bsg_strobe_shape
    import bus_strobe_pkg::*;
#(
    parameter int PHASES_PER_STATE = 2,
    parameter int PHASE_W          = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_nx,
    input  mc_attr_t           attr_nx,
    output logic               addr_latch,
    output logic               prog_rd_n
);
    // Pulse windows derived from the state length.
    localparam int LATCH_W  = PHASES_PER_STATE;
    localparam int LATCH_A  = 0;
    localparam int LATCH_B  = 3 * PHASES_PER_STATE;
    localparam int READ_W   = PHASES_PER_STATE + 1;
    localparam int READ_A   = LATCH_A + LATCH_W + 1;
    localparam int READ_B   = LATCH_B + LATCH_W + 1;

    typedef struct packed {
        logic latch;
        logic rd_n;
    } st_t;

    st_t st_d, st_q;

    function automatic logic in_win(input logic [PHASE_W-1:0] ph,
                                    input int start, input int width);
        int p;
        p = int'(ph);
        return (p >= start) && (p < start + width);
    endfunction

    logic win_a, win_b, rd_win, latch_en;

    always_comb begin
        win_a    = in_win(phase_nx, LATCH_A, LATCH_W) && !attr_nx.xdata;
        win_b    = in_win(phase_nx, LATCH_B, LATCH_W);
        rd_win   = in_win(phase_nx, READ_A, READ_W) ||
                   in_win(phase_nx, READ_B, READ_W);
        latch_en = attr_nx.ext || !attr_nx.quiet ||
                   attr_nx.xdata || attr_nx.code_rd;

        st_d = st_q;
        if (rst) begin
            st_d.latch = 1'b0;
            st_d.rd_n  = 1'b1;
        end else begin
            st_d.latch = latch_en ? (win_a || win_b) : 1'b1;
            st_d.rd_n  = !(attr_nx.ext && !attr_nx.xdata && rd_win);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_latch = st_q.latch;
    assign prog_rd_n  = st_q.rd_n;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int PHASES_PER_STATE = 2,
    parameter int STATES_PER_MC    = 6,
    parameter int RST_HOLD_MC      = 2,
    parameter int SYNC_STAGES      = 2
) (
    input  logic       osc_clk,
    input  logic       rst_pin,
    input  logic       mc_xdata,
    input  logic       mc_code_rd,
    input  logic       latch_quiet,
    input  logic       ext_fetch,
    output logic       addr_latch,
    output logic       prog_rd_n,
    output logic [3:0] mc_phase,
    output logic       rst_int
);
    localparam int MC_LEN  = PHASES_PER_STATE * STATES_PER_MC;
    localparam int PHASE_W = 4;

    mc_attr_t           attr_in, attr_nx;
    logic [PHASE_W-1:0] phase_q, phase_nx;

    assign attr_in = '{xdata: mc_xdata, code_rd: mc_code_rd,
                       quiet: latch_quiet, ext: ext_fetch};

    bsg_rst_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYCLES (RST_HOLD_MC * MC_LEN)
    ) u_rst (
        .clk     (osc_clk),
        .rst_pin (rst_pin),
        .rst_int (rst_int)
    );

    bsg_cycle_seq #(
        .MC_LEN  (MC_LEN),
        .PHASE_W (PHASE_W)
    ) u_seq (
        .clk      (osc_clk),
        .rst      (rst_int),
        .attr_in  (attr_in),
        .phase    (phase_q),
        .phase_nx (phase_nx),
        .attr_nx  (attr_nx)
    );

    bsg_strobe_shape #(
        .PHASES_PER_STATE (PHASES_PER_STATE),
        .PHASE_W          (PHASE_W)
    ) u_shape (
        .clk        (osc_clk),
        .rst        (rst_int),
        .phase_nx   (phase_nx),
        .attr_nx    (attr_nx),
        .addr_latch (addr_latch),
        .prog_rd_n  (prog_rd_n)
    );

    assign mc_phase = phase_q;

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
    parameter int MC_LEN = 12
) (
    input logic       clk,
    input logic       rst_int,
    input logic       addr_latch,
    input logic       prog_rd_n,
    input logic [3:0] mc_phase
);
    // R1: every latch pulse spans at least two periods
    p_latch_two_wide_r1: assert property (@(posedge clk) disable iff (rst_int)
        $rose(addr_latch) |=> addr_latch);

    // R5: every program-read pulse spans three periods
    p_read_three_wide_r5: assert property (@(posedge clk) disable iff (rst_int)
        $fell(prog_rd_n) |=> !prog_rd_n ##1 !prog_rd_n);

    // R5: program read never overlaps a latch pulse
    p_read_no_overlap_r5: assert property (@(posedge clk) disable iff (rst_int)
        !prog_rd_n |-> !addr_latch);

    // R10: phase wraps after the last phase and stays in range
    p_phase_wrap_r10: assert property (@(posedge clk) disable iff (rst_int)
        mc_phase == 4'(MC_LEN - 1) |=> mc_phase == 4'd0);

    p_phase_range_r10: assert property (@(posedge clk) disable iff (rst_int)
        mc_phase < 4'(MC_LEN));

    // R9: held reset parks both strobes and the phase
    p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_int)
        $past(rst_int) |-> (!addr_latch && prog_rd_n && mc_phase == 4'd0));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.MC_LEN(MC_LEN)) u_chk (
    .clk        (osc_clk),
    .rst_int    (rst_int),
    .addr_latch (addr_latch),
    .prog_rd_n  (prog_rd_n),
    .mc_phase   (mc_phase)
);

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;
    logic       osc_clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic       mc_xdata = 1'b0, mc_code_rd = 1'b0;
    logic       latch_quiet = 1'b0, ext_fetch = 1'b0;
    logic       addr_latch, prog_rd_n, rst_int;
    logic [3:0] mc_phase;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 osc_clk = ~osc_clk;

    bus_strobe_gen u_dut (
        .osc_clk     (osc_clk),
        .rst_pin     (rst_pin),
        .mc_xdata    (mc_xdata),
        .mc_code_rd  (mc_code_rd),
        .latch_quiet (latch_quiet),
        .ext_fetch   (ext_fetch),
        .addr_latch  (addr_latch),
        .prog_rd_n   (prog_rd_n),
        .mc_phase    (mc_phase),
        .rst_int     (rst_int)
    );

    // {xdata, code_rd, quiet, ext, latch mask[11:0], read_n mask[11:0]}
    // mask bit p is the expected level in phase p
    localparam int NV = 9;
    localparam logic [27:0] VEC [NV] = '{
        {4'b0000, 12'h0C3, 12'hFFF},
        {4'b0001, 12'h0C3, 12'h1C7},
        {4'b1001, 12'h0C0, 12'hFFF},
        {4'b0010, 12'hFFF, 12'hFFF},
        {4'b1010, 12'h0C0, 12'hFFF},
        {4'b0110, 12'h0C3, 12'hFFF},
        {4'b0011, 12'h0C3, 12'h1C7},
        {4'b1000, 12'h0C0, 12'hFFF},
        {4'b0101, 12'h0C3, 12'h1C7}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a);
        {mc_xdata, mc_code_rd, latch_quiet, ext_fetch} = a;
    endtask

    function automatic string tag_for(input logic [3:0] a);
        if (a[3]) return "R2/R6";
        if (a[0]) return a[1] ? "R4" : "R5";
        return a[1] ? "R3" : "R1";
    endfunction

    // One machine cycle, sampled on falling edges from phase 0.
    task automatic run_mc(input logic [11:0] am, input logic [11:0] pm, input string req,
                          input logic [3:0] nxt, input int swap_at, input logic [3:0] swap_val);
        for (int p = 0; p < 12; p++) begin
            @(negedge osc_clk);
            chk("R10", "phase", int'(mc_phase), p);
            chk(req, $sformatf("addr_latch phase %0d", p), int'(addr_latch), int'(am[p]));
            chk(req, $sformatf("prog_rd_n phase %0d", p), int'(prog_rd_n), int'(pm[p]));
            if (p == swap_at) drive(swap_val);
            if (p == 11) drive(nxt);
        end
    endtask

    initial begin
        repeat (20000) @(posedge osc_clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        drive(4'b0000);
        repeat (4) @(negedge osc_clk);

        // R8 / R9: qualified reset assertion
        rst_pin = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge osc_clk);
            if (k == 25) chk("R8", "rst_int before hold", int'(rst_int), 0);
            if (k == 26) chk("R8", "rst_int after hold", int'(rst_int), 1);
            if (k == 27 || k == 30) begin
                chk("R9", "addr_latch in reset", int'(addr_latch), 0);
                chk("R9", "prog_rd_n in reset", int'(prog_rd_n), 1);
                chk("R9", "phase in reset", int'(mc_phase), 0);
            end
        end

        // release
        drive(VEC[0][27:24]);
        rst_pin = 1'b0;
        @(negedge osc_clk);
        chk("R8", "rst_int release+1", int'(rst_int), 1);
        @(negedge osc_clk);
        chk("R8", "rst_int release+2", int'(rst_int), 1);
        @(negedge osc_clk);
        chk("R8", "rst_int release+3", int'(rst_int), 0);
        chk("R9", "addr_latch before start", int'(addr_latch), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            run_mc(VEC[v][23:12], VEC[v][11:0], tag_for(VEC[v][27:24]),
                   (v < NV - 1) ? VEC[v + 1][27:24] : 4'b0001, -1, 4'b0000);
        end

        // R7: mid-cycle input change must not affect the running cycle
        run_mc(12'h0C3, 12'h1C7, "R7", 4'b0000, 4, 4'b1010);
        run_mc(12'h0C3, 12'hFFF, "R7", 4'b0000, -1, 4'b0000);

        // R8: short pin pulse is ignored, phase count undisturbed
        rst_pin = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge osc_clk);
            if (rst_int) chk("R8", "rst_int during short pulse", int'(rst_int), 0);
        end
        chk("R8", "rst_int short pulse end", int'(rst_int), 0);
        rst_pin = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge osc_clk);
            if (rst_int) chk("R8", "rst_int after short pulse", int'(rst_int), 0);
        end
        chk("R8", "phase after short pulse", int'(mc_phase), (11 + 24) % 12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule